// File: doc/BRIEF.md
# Register-Controlled Barrel Shifter Unit

This unit produces the second operand of a data-processing datapath together with the carry that the shifter hands to the flag logic. It has two modes. In register-amount mode a 32-bit operand is shifted or rotated by an amount that is read from a register. The shift can be a logical left, logical right, arithmetic right or rotate right. In immediate mode a small constant is zero-extended to the full width and rotated right by twice a short rotate field. Most common constants, all powers of two among them, can be built this way.

Register amounts cover the whole range of the low byte of the amount register, 0 to 255. Each shift kind has its own rule for amounts of 32 and above, so the outcome is defined for every byte value. The shifting logic is combinational. An optional output register, on by default, holds the result and the carry. It loads only when its enable is high and clears on an asynchronous active-low reset. That reset is expected to be released in step with the clock.

Top module: `bshift_unit`

## Requirements
- R1: In register-amount mode, `shift_kind` selects the shift: 00 is logical left, 01 is logical right, 10 is arithmetic right and 11 is rotate right. For amounts from 1 to 31 the result is the standard shift of the operand. The carry is the last bit shifted out: bit 32-n for a left shift and bit n-1 for the right shifts and the rotate.
- R2: A register amount of 0 leaves the operand unchanged as the result, and the carry equals `carry_in`, for every shift kind.
- R3: A logical left shift by exactly 32 gives a zero result with carry equal to operand bit 0. A logical left shift by more than 32 gives zero and carry 0.
- R4: A logical right shift by exactly 32 gives a zero result with carry equal to operand bit 31. A logical right shift by more than 32 gives zero and carry 0.
- R5: An arithmetic right shift by 32 or more sets every result bit to operand bit 31, and the carry is also operand bit 31.
- R6: A rotate by a nonzero multiple of 32 returns the operand unchanged with carry equal to operand bit 31. Any other rotate above 32 acts as a rotate by the amount modulo 32.
- R7: When `imm_mode` is 1, `imm_value` is zero-extended to 32 bits and rotated right by twice `rot_field`. With a nonzero field the carry is bit 31 of the rotated value.
- R8: When `imm_mode` is 1 and `rot_field` is 0, the result is the zero-extended `imm_value` and the carry equals `carry_in`.
- R9: Only bits 7:0 of `amount` set the shift amount. Bits 31:8 have no effect on the result or the carry.
- R10: With the output register present, `result` and `carry_out` show the outcome of the inputs that were present at the last rising edge with `en` high. They hold while `en` is low, and they are 0 while reset is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| en | input | 1 | Load enable for the output register |
| imm_mode | input | 1 | 1 selects immediate rotate, 0 selects register-amount shift |
| shift_kind | input | 2 | 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right |
| operand | input | 32 | Value to be shifted in register-amount mode |
| amount | input | 32 | Amount register; only bits 7:0 are used |
| imm_value | input | 8 | Constant for immediate mode |
| rot_field | input | 4 | Immediate rotate field; the rotate is twice this value |
| carry_in | input | 1 | Current carry flag |
| result | output | 32 | Shifted or rotated value |
| carry_out | output | 1 | Shifter carry |

## Verification
The bench aims at the points where the shift-kind rules split: amounts 0, 1, 31, 32, 33, 64 and 255 for each kind, with random operands. Each split has its own failure mode. A left shift at 32 that loses bit 0 from the carry would report a wrong flag. An arithmetic shift that returns zero at 32 or more would drop the sign. A rotate that treats a multiple of 32 as zero would hand back `carry_in` where operand bit 31 belongs. A design that forgets that an amount of 0 passes `carry_in` through would corrupt the flags on every unshifted operand. Amounts with the upper register bits set catch a design that decodes more than the low byte. Every rotate field in immediate mode, including 0, checks the doubling and the carry choice. A check with the enable low confirms that the output register holds its value.

// File: rtl/bshift_pkg.sv
package bshift_pkg;
  typedef enum logic [1:0] {
    SK_LSL = 2'b00,
    SK_LSR = 2'b01,
    SK_ASR = 2'b10,
    SK_ROR = 2'b11
  } shift_kind_e;
endpackage

// File: rtl/bshift_reg_core.sv
module bshift_reg_core
  import bshift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8
) (
  input  logic [DATA_W-1:0] operand,
  input  shift_kind_e       kind,
  input  logic [AMT_W-1:0]  amt,
  input  logic              carry_in,
  output logic [DATA_W-1:0] result,
  output logic              carry_out
);
  localparam int SH_W = $clog2(DATA_W);
  localparam logic [AMT_W-1:0] FULL = AMT_W'(DATA_W);

  logic [DATA_W:0]     lsl_ext;
  logic [DATA_W:0]     lsr_ext;
  logic [DATA_W:0]     asr_ext;
  logic [AMT_W-1:0]    asr_amt;
  logic [SH_W-1:0]     ror_amt;
  logic [2*DATA_W-1:0] ror_dbl;

  // One bit of headroom on the shifted side captures the last bit out,
  // which covers the 32 and above cases without extra decoding.
  always_comb begin
    lsl_ext = {1'b0, operand} << amt;
    lsr_ext = {operand, 1'b0} >> amt;
    asr_amt = (amt >= FULL) ? FULL : amt;
    asr_ext = $signed({operand, 1'b0}) >>> asr_amt;
    ror_amt = amt[SH_W-1:0];
    ror_dbl = {operand, operand} >> ror_amt;
  end

  always_comb begin
    result    = operand;
    carry_out = carry_in;
    if (amt != '0) begin
      unique case (kind)
        SK_LSL: begin
          result    = lsl_ext[DATA_W-1:0];
          carry_out = lsl_ext[DATA_W];
        end
        SK_LSR: begin
          result    = lsr_ext[DATA_W:1];
          carry_out = lsr_ext[0];
        end
        SK_ASR: begin
          result    = asr_ext[DATA_W:1];
          carry_out = asr_ext[0];
        end
        default: begin
          result    = ror_dbl[DATA_W-1:0];
          carry_out = ror_dbl[DATA_W-1];
        end
      endcase
    end
  end
endmodule

// File: rtl/bshift_imm_rot.sv
module bshift_imm_rot #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4
) (
  input  logic [IMM_W-1:0]  imm,
  input  logic [ROT_W-1:0]  rot,
  input  logic              carry_in,
  output logic [DATA_W-1:0] result,
  output logic              carry_out
);
  logic [DATA_W-1:0]   ext;
  logic [ROT_W:0]      rot2;
  logic [2*DATA_W-1:0] dbl;

  always_comb begin
    ext       = DATA_W'(imm);
    rot2      = {rot, 1'b0};
    dbl       = {ext, ext} >> rot2;
    result    = dbl[DATA_W-1:0];
    carry_out = (rot == '0) ? carry_in : dbl[DATA_W-1];
  end
endmodule

// File: rtl/bshift_out_stage.sv
module bshift_out_stage #(
  parameter int DATA_W  = 32,
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [DATA_W-1:0] d_res,
  input  logic              d_c,
  output logic [DATA_W-1:0] q_res,
  output logic              q_c
);
  generate
    if (OUT_REG) begin : g_reg
      logic [DATA_W-1:0] res_q, res_d;
      logic              c_q, c_d;

      always_comb begin
        res_d = res_q;
        c_d   = c_q;
        if (en) begin
          res_d = d_res;
          c_d   = d_c;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          res_q <= '0;
          c_q   <= 1'b0;
        end else begin
          res_q <= res_d;
          c_q   <= c_d;
        end
      end

      assign q_res = res_q;
      assign q_c   = c_q;
    end else begin : g_comb
      assign q_res = d_res;
      assign q_c   = d_c;
    end
  endgenerate
endmodule

// File: rtl/bshift_unit.sv
module bshift_unit
  import bshift_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int AMT_W   = 8,
  parameter int IMM_W   = 8,
  parameter int ROT_W   = 4,
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              imm_mode,
  input  logic [1:0]        shift_kind,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] amount,
  input  logic [IMM_W-1:0]  imm_value,
  input  logic [ROT_W-1:0]  rot_field,
  input  logic              carry_in,
  output logic [DATA_W-1:0] result,
  output logic              carry_out
);
  logic [DATA_W-1:0] reg_res, imm_res, sel_res;
  logic              reg_c, imm_c, sel_c;

  bshift_reg_core #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_core (
    .operand  (operand),
    .kind     (shift_kind_e'(shift_kind)),
    .amt      (amount[AMT_W-1:0]),
    .carry_in (carry_in),
    .result   (reg_res),
    .carry_out(reg_c)
  );

  bshift_imm_rot #(.DATA_W(DATA_W), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_imm (
    .imm      (imm_value),
    .rot      (rot_field),
    .carry_in (carry_in),
    .result   (imm_res),
    .carry_out(imm_c)
  );

  always_comb begin
    sel_res = imm_mode ? imm_res : reg_res;
    sel_c   = imm_mode ? imm_c   : reg_c;
  end

  bshift_out_stage #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_out (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (en),
    .d_res(sel_res),
    .d_c  (sel_c),
    .q_res(result),
    .q_c  (carry_out)
  );
endmodule

// File: rtl/bshift_chk.sv
module bshift_chk #(
  parameter int DATA_W  = 32,
  parameter int AMT_W   = 8,
  parameter int IMM_W   = 8,
  parameter int ROT_W   = 4,
  parameter bit OUT_REG = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              imm_mode,
  input logic [1:0]        shift_kind,
  input logic [DATA_W-1:0] operand,
  input logic [DATA_W-1:0] amount,
  input logic [IMM_W-1:0]  imm_value,
  input logic [ROT_W-1:0]  rot_field,
  input logic              carry_in,
  input logic [DATA_W-1:0] result,
  input logic              carry_out
);
  localparam logic [AMT_W-1:0] FULL = AMT_W'(DATA_W);

  logic primed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  generate
    if (OUT_REG) begin : g_props
      assert_zero_amt_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
        primed && $past(en && !imm_mode && amount[AMT_W-1:0] == '0)
        |-> result == $past(operand) && carry_out == $past(carry_in));

      assert_lsl_wide_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        primed && $past(en && !imm_mode && shift_kind == 2'b00 && amount[AMT_W-1:0] >= FULL)
        |-> result == '0);

      assert_lsr_over_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        primed && $past(en && !imm_mode && shift_kind == 2'b01 && amount[AMT_W-1:0] > FULL)
        |-> result == '0 && !carry_out);

      assert_asr_sign_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        primed && $past(en && !imm_mode && shift_kind == 2'b10 && amount[AMT_W-1:0] >= FULL)
        |-> result == {DATA_W{$past(operand[DATA_W-1])}} && carry_out == $past(operand[DATA_W-1]));

      assert_ror_whole_turn_R6: assert property (@(posedge clk) disable iff (!rst_n)
        primed && $past(en && !imm_mode && shift_kind == 2'b11 && amount[AMT_W-1:0] != '0
                        && amount[$clog2(DATA_W)-1:0] == '0)
        |-> result == $past(operand) && carry_out == $past(operand[DATA_W-1]));

      assert_imm_norot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        primed && $past(en && imm_mode && rot_field == '0)
        |-> result == DATA_W'($past(imm_value)) && carry_out == $past(carry_in));

      assert_imm_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        primed && $past(en && imm_mode && rot_field != '0)
        |-> carry_out == result[DATA_W-1]);

      assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        primed && !$past(en) |-> $stable(result) && $stable(carry_out));
    end
  endgenerate
endmodule

bind bshift_unit bshift_chk #(
  .DATA_W(DATA_W), .AMT_W(AMT_W), .IMM_W(IMM_W), .ROT_W(ROT_W), .OUT_REG(OUT_REG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .imm_mode(imm_mode), .shift_kind(shift_kind),
  .operand(operand), .amount(amount), .imm_value(imm_value), .rot_field(rot_field),
  .carry_in(carry_in), .result(result), .carry_out(carry_out)
);

// File: tb/bshift_unit_bench.sv
`timescale 1ns/1ps
module bshift_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        en;
  logic        imm_mode;
  logic [1:0]  shift_kind;
  logic [31:0] operand;
  logic [31:0] amount;
  logic [7:0]  imm_value;
  logic [3:0]  rot_field;
  logic        carry_in;
  logic [31:0] result;
  logic        carry_out;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bshift_unit u_bshift_unit (
    .clk(clk), .rst_n(rst_n), .en(en), .imm_mode(imm_mode), .shift_kind(shift_kind),
    .operand(operand), .amount(amount), .imm_value(imm_value), .rot_field(rot_field),
    .carry_in(carry_in), .result(result), .carry_out(carry_out)
  );

  // Bit-at-a-time reference: returns {carry, result}
  function automatic logic [32:0] ref_reg(input logic [1:0] k, input logic [31:0] v,
                                          input logic [7:0] n, input logic c);
    for (int i = 0; i < int'(n); i++) begin
      case (k)
        2'b00:   begin c = v[31]; v = {v[30:0], 1'b0}; end
        2'b01:   begin c = v[0];  v = {1'b0, v[31:1]}; end
        2'b10:   begin c = v[0];  v = {v[31], v[31:1]}; end
        default: begin c = v[0];  v = {v[0], v[31:1]}; end
      endcase
    end
    return {c, v};
  endfunction

  function automatic logic [32:0] ref_imm(input logic [7:0] im, input logic [3:0] r,
                                          input logic c);
    logic [31:0] v = {24'd0, im};
    for (int i = 0; i < 2 * int'(r); i++) v = {v[0], v[31:1]};
    return {(r == 4'd0) ? c : v[31], v};
  endfunction

  function automatic string tag_for(input logic [1:0] k, input logic [7:0] n);
    if (n == 8'd0) return "R2";
    if (n < 8'd32) return "R1";
    case (k)
      2'b00:   return "R3";
      2'b01:   return "R4";
      2'b10:   return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string tag, input logic [32:0] exp);
    compared++;
    if ({carry_out, result} !== exp) begin
      mismatched++;
      $display("FAIL %s: got res=%h c=%b expected res=%h c=%b",
               tag, result, carry_out, exp[31:0], exp[32]);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  task automatic run_reg(input logic [1:0] k, input logic [31:0] v, input logic [31:0] a,
                         input logic c, input string tag);
    en = 1'b1; imm_mode = 1'b0; shift_kind = k; operand = v; amount = a; carry_in = c;
    imm_value = 8'($urandom); rot_field = 4'($urandom);
    @(posedge clk); @(negedge clk);
    check(tag, ref_reg(k, v, a[7:0], c));
  endtask

  task automatic run_imm(input logic [7:0] im, input logic [3:0] r, input logic c);
    en = 1'b1; imm_mode = 1'b1; imm_value = im; rot_field = r; carry_in = c;
    operand = $urandom; amount = $urandom; shift_kind = 2'($urandom);
    @(posedge clk); @(negedge clk);
    check((r == 4'd0) ? "R8" : "R7", ref_imm(im, r, c));
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      mismatched++;
      $display("FAIL R10: watchdog expired, got no completion expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] amts [7] = '{8'd0, 8'd1, 8'd31, 8'd32, 8'd33, 8'd64, 8'd255};
    logic [32:0] held;
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; en = 1'b0; imm_mode = 1'b0; shift_kind = 2'b00;
    operand = '0; amount = '0; imm_value = '0; rot_field = '0; carry_in = 1'b0;
    repeat (3) @(negedge clk);
    // R10: reset state, even with en and inputs active
    en = 1'b1; operand = 32'hFFFF_FFFF; amount = 32'd1; carry_in = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R10", 33'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed corners per kind, with sign bit set and clear
    for (int k = 0; k < 4; k++)
      for (int a = 0; a < 7; a++)
        for (int p = 0; p < 3; p++) begin
          logic [31:0] v = (p == 0) ? 32'h8000_0001 : (p == 1) ? 32'h7FFF_FFFE : $urandom;
          run_reg(2'(k), v, {24'd0, amts[a]}, 1'(p), tag_for(2'(k), amts[a]));
          run_reg(2'(k), v, {24'd0, amts[a]}, ~1'(p), tag_for(2'(k), amts[a]));
        end

    // R9: upper amount bits set must not matter
    for (int i = 0; i < 40; i++) begin
      logic [31:0] a = {24'($urandom) | 24'h1, 8'($urandom)};
      run_reg(2'($urandom), $urandom, a, 1'($urandom), "R9");
    end

    // R7 / R8: every rotate field
    for (int r = 0; r < 16; r++) begin
      run_imm(8'($urandom) | 8'h81, 4'(r), 1'b0);
      run_imm(8'($urandom), 4'(r), 1'b1);
    end

    // R10: hold with enable low
    run_reg(2'b11, 32'hDEAD_BEEF, 32'd4, 1'b0, "R1");
    held = ref_reg(2'b11, 32'hDEAD_BEEF, 8'd4, 1'b0);
    en = 1'b0; operand = 32'h1234_5678; amount = 32'd9; carry_in = 1'b1; imm_mode = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R10", held);

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 3) == 0)
        run_imm(8'($urandom), 4'($urandom), 1'($urandom));
      else begin
        logic [31:0] a = ($urandom_range(0, 1) == 0) ? {27'd0, 5'($urandom)} : $urandom;
        logic [1:0] k = 2'($urandom);
        run_reg(k, $urandom, a, 1'($urandom), tag_for(k, a[7:0]));
      end
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule